// File: doc/BRIEF.md
# Periodic LAPD Message Frame Transmitter

This block sends a short data-link message, held in a small internal buffer, as an HDLC/LAPD frame over a narrow overhead channel. The outbound framer offers the block one octet slot per outbound frame. The framer can strobe either of two overhead byte positions, GC or NR, and a select input decides which of the two carries the channel. Each octet of the serialised bit stream leaves the block on a strobe of the selected position. The other position's strobes are ignored.

A frame consists of an opening flag, the message bytes, a 16-bit frame check sequence and a closing flag. Zero-bit insertion covers the message and the check sequence, but not the flags. Between frames the channel carries a continuous run of flags. A rising edge on the start control begins a transmission. While start stays high, the same frame is sent again each time a repeat interval elapses. The interval is measured in selected slot strobes, and its default equals one second of outbound frames. A busy status shows that a frame is pending or in progress. A sticky completion status, cleared by a status read, drives an interrupt line through an enable.

Top module: `lapd_msg_tx`

## Requirements
- R1: After five consecutive 1 bits taken from the message or the check sequence, a 0 bit is inserted into the stream. Flag octets are never stuffed, so the line never carries seven consecutive 1 bits.
- R2: A frame on the line is built as follows:
  - It is a 0x7E flag, then the msg_len buffer bytes in address order, then the check sequence, then a 0x7E flag.
  - Each byte is sent least significant bit first.
  - The check sequence is CRC-16 with initial value 0xFFFF, reflected polynomial 0x8408, processed bit by bit LSB first. It is sent complemented, low byte first.
  - Bit 0 of every output octet is the earliest bit on the line.
- R3: When no frame is being sent, the bit stream is back-to-back 0x7E flags. The first octet delivered after reset is 0x7E.
- R4: A frame is started only by a 0-to-1 change of start. If start is pulsed and then returned to 0, exactly one frame is sent.
- R5: While start stays 1, a new frame is begun each time REPEAT_SLOTS selected slot strobes have elapsed since the previous frame began. A frame begins at the next flag boundary. Once start is 0, no further repeat is begun.
- R6: Slot mapping and output timing:
  - slot_sel = 0 selects the GC strobe (slot_gc) and slot_sel = 1 selects the NR strobe (slot_nr).
  - Each selected strobe yields oct_valid high for exactly one cycle, one clock later, with the next octet on oct_data.
  - A strobe of the unselected position yields nothing.
  - Selected strobes must be at least 16 clocks apart.
- R7: busy goes to 1 in the cycle after a rising edge of start. It stays 1 while a frame is pending or being sent. It returns to 0 once the last check-sequence bit has been emitted.
- R8: int_status is 0 after reset. It becomes 1 in the cycle after a frame's last check-sequence bit is emitted, and it stays 1 through further completions until status_rd is pulsed. A completion coinciding with a read leaves it set.
- R9: irq equals int_status when irq_en is 1 and is 0 when irq_en is 0.
- R10: Message bytes are written with msg_we, msg_waddr and msg_wdata. The frame length msg_len is captured when the frame begins and may be 1 to MSG_DEPTH. A value of 0 is treated as 1 and a value above MSG_DEPTH as MSG_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start control level; its rising edge requests a frame |
| irq_en | input | 1 | Interrupt enable |
| status_rd | input | 1 | Status read strobe; clears int_status |
| slot_sel | input | 1 | Overhead position select: 0 = GC, 1 = NR |
| slot_gc | input | 1 | GC octet slot strobe from the framer |
| slot_nr | input | 1 | NR octet slot strobe from the framer |
| msg_we | input | 1 | Message buffer write enable |
| msg_waddr | input | 4 | Message buffer write address |
| msg_wdata | input | 8 | Message buffer write data |
| msg_len | input | 5 | Message length in bytes |
| oct_data | output | 8 | Octet for the current slot |
| oct_valid | output | 1 | One-cycle pulse marking oct_data |
| busy | output | 1 | Frame pending or in progress |
| int_status | output | 1 | Sticky frame-complete status |
| irq | output | 1 | Gated interrupt |

## Verification
The bench flattens the delivered octets into a bit stream and runs an HDLC receiver on it, so the corner cases below show up as decoding failures.
- **Missing stuffing.** The first message contains 0xFF, 0x7E and byte runs of five ones. A stuffer that missed one of these, or that stuffed a flag, would show up as an abort or as a phantom flag that splits the frame.
- **Trailing stuff bit.** A design that dropped the stuff bit owed at the very end of the check sequence would corrupt the closing flag.
- **Check sequence and length.** A wrong CRC seed, bit order, complement or byte order would fail the byte comparison. So would a length bound that is off by one; the 1-byte and 16-byte messages cover both ends of the length range.
- **Start handling and repeats.** A level-triggered start, or a repeat that ignored start going low, would deliver frames the scoreboard does not expect. A mis-counted interval would fail the spacing check between repeated frames.
- **Slot mapping.** A design that answered the unselected strobe would deliver roughly twice as many octets as selected strobes.
- **Sticky status.** A status that tracked each completion only briefly would be found at 0 after several unread completions.

// File: rtl/lapd_tx_pkg.sv
package lapd_tx_pkg;

    localparam logic [7:0]  FLAG_OCT = 8'h7E;
    localparam logic [15:0] CRC_POLY = 16'h8408;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [1:0] {
        SEG_FLAG,
        SEG_BODY,
        SEG_FCS
    } seg_e;

    typedef struct packed {
        logic [7:0] shreg;
        logic [3:0] fill;
    } collect_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/lapd_msg_buf.sv
module lapd_msg_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/lapd_bit_src.sv
module lapd_bit_src
    import lapd_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          go,
    input  logic [LW-1:0] msg_len,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          bit_out,
    output logic          frame_take,
    output logic          frame_done
);

    seg_e          seg;
    logic [2:0]    bidx;
    logic [AW-1:0] bptr;
    logic [3:0]    fidx;
    logic [LW-1:0] len_q;
    logic [15:0]   crc;
    logic [15:0]   fcs;
    logic [2:0]    ones;
    logic          stuff;
    logic          raw;
    logic          last_byte;
    logic [15:0]   crc_nx;
    logic [LW-1:0] len_clamped;

    assign stuff     = (ones == 3'd5);
    assign rd_addr   = bptr;
    assign last_byte = (LW'(bptr) == len_q - LW'(1));
    assign crc_nx    = crc_step(crc, raw);

    always_comb begin
        unique case (seg)
            SEG_FLAG: raw = FLAG_OCT[bidx];
            SEG_BODY: raw = rd_data[bidx];
            default:  raw = fcs[fidx];
        endcase
    end

    always_comb begin
        if (msg_len == '0)              len_clamped = LW'(1);
        else if (msg_len > LW'(DEPTH))  len_clamped = LW'(DEPTH);
        else                            len_clamped = msg_len;
    end

    assign bit_out    = stuff ? 1'b0 : raw;
    assign frame_take = adv && !stuff && (seg == SEG_FLAG) && (bidx == 3'd7) && go;
    assign frame_done = adv && !stuff && (seg == SEG_FCS) && (fidx == 4'd15);

    always_ff @(posedge clk) begin
        if (rst) begin
            seg   <= SEG_FLAG;
            bidx  <= '0;
            bptr  <= '0;
            fidx  <= '0;
            len_q <= LW'(1);
            crc   <= CRC_INIT;
            fcs   <= '0;
            ones  <= '0;
        end else if (adv) begin
            if (stuff) begin
                ones <= '0;
            end else begin
                unique case (seg)
                    SEG_FLAG: begin
                        ones <= '0;
                        bidx <= bidx + 3'd1;
                        if (frame_take) begin
                            seg   <= SEG_BODY;
                            bptr  <= '0;
                            len_q <= len_clamped;
                            crc   <= CRC_INIT;
                        end
                    end
                    SEG_BODY: begin
                        ones <= raw ? ones + 3'd1 : 3'd0;
                        crc  <= crc_nx;
                        bidx <= bidx + 3'd1;
                        if (bidx == 3'd7) begin
                            if (last_byte) begin
                                seg  <= SEG_FCS;
                                fidx <= '0;
                                fcs  <= ~crc_nx;
                            end else begin
                                bptr <= bptr + AW'(1);
                            end
                        end
                    end
                    default: begin
                        ones <= raw ? ones + 3'd1 : 3'd0;
                        fidx <= fidx + 4'd1;
                        if (fidx == 4'd15) begin
                            seg  <= SEG_FLAG;
                            bidx <= '0;
                        end
                    end
                endcase
            end
        end
    end

    // R1
    stuff_run_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !stuff && seg != SEG_FLAG) |-> (ones < 3'd5));

endmodule

// File: rtl/lapd_oct_pack.sv
module lapd_oct_pack
    import lapd_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_in,
    input  logic       slot_sel,
    input  logic       slot_gc,
    input  logic       slot_nr,
    output logic       adv,
    output logic       slot_tick,
    output logic [7:0] oct_data,
    output logic       oct_valid
);

    collect_t   col;
    logic [7:0] rdy;
    logic       rdy_full;
    logic       load;
    logic [2:0] ones_run;

    assign adv       = (col.fill != 4'd8);
    assign load      = !adv && !rdy_full;
    assign slot_tick = slot_sel ? slot_nr : slot_gc;

    always_ff @(posedge clk) begin
        if (rst) begin
            col       <= '0;
            rdy       <= FLAG_OCT;
            rdy_full  <= 1'b0;
            oct_data  <= FLAG_OCT;
            oct_valid <= 1'b0;
            ones_run  <= '0;
        end else begin
            oct_valid <= slot_tick;
            if (slot_tick) oct_data <= rdy_full ? rdy : FLAG_OCT;
            if (adv) begin
                col.shreg <= {bit_in, col.shreg[7:1]};
                col.fill  <= col.fill + 4'd1;
                ones_run  <= bit_in ? ((ones_run == 3'd7) ? 3'd7 : ones_run + 3'd1) : 3'd0;
            end else if (load) begin
                rdy      <= col.shreg;
                col.fill <= '0;
            end
            if (load)           rdy_full <= 1'b1;
            else if (slot_tick) rdy_full <= 1'b0;
        end
    end

    // R1
    no_seven_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && bit_in) |-> (ones_run < 3'd6));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        slot_tick |-> rdy_full);

endmodule

// File: rtl/lapd_tx_ctl.sv
module lapd_tx_ctl #(
    parameter int REPEAT_SLOTS = 22375,
    parameter int TW           = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic slot_tick,
    input  logic frame_take,
    input  logic frame_done,
    input  logic status_rd,
    input  logic irq_en,
    output logic go,
    output logic busy,
    output logic int_status,
    output logic irq
);

    logic          start_q;
    logic          rise;
    logic          running;
    logic          pend;
    logic          in_frame;
    logic          expire;
    logic [TW-1:0] tmr;

    assign rise   = start && !start_q;
    assign expire = slot_tick && (tmr == TW'(REPEAT_SLOTS - 1));
    assign go     = pend;
    assign busy   = pend || in_frame;
    assign irq    = int_status && irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q    <= 1'b0;
            running    <= 1'b0;
            pend       <= 1'b0;
            in_frame   <= 1'b0;
            int_status <= 1'b0;
            tmr        <= '0;
        end else begin
            start_q <= start;
            if (rise)        running <= 1'b1;
            else if (!start) running <= 1'b0;
            if (frame_take)
                tmr <= '0;
            else if (slot_tick && tmr != TW'(REPEAT_SLOTS - 1))
                tmr <= tmr + TW'(1);
            pend <= rise || (running && expire && !frame_take) || (pend && !frame_take);
            if (frame_take)      in_frame <= 1'b1;
            else if (frame_done) in_frame <= 1'b0;
            if (frame_done)     int_status <= 1'b1;
            else if (status_rd) int_status <= 1'b0;
        end
    end

    // R4
    busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(start) |=> busy);

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(frame_done));

    // R8
    int_set_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> int_status);

    // R8
    int_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (int_status && !status_rd) |=> int_status);

endmodule

// File: rtl/lapd_msg_tx.sv
module lapd_msg_tx #(
    parameter int MSG_DEPTH    = 16,
    parameter int REPEAT_SLOTS = 22375,
    localparam int AW = $clog2(MSG_DEPTH),
    localparam int LW = $clog2(MSG_DEPTH + 1),
    localparam int TW = $clog2(REPEAT_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          irq_en,
    input  logic          status_rd,
    input  logic          slot_sel,
    input  logic          slot_gc,
    input  logic          slot_nr,
    input  logic          msg_we,
    input  logic [AW-1:0] msg_waddr,
    input  logic [7:0]    msg_wdata,
    input  logic [LW-1:0] msg_len,
    output logic [7:0]    oct_data,
    output logic          oct_valid,
    output logic          busy,
    output logic          int_status,
    output logic          irq
);

    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          adv;
    logic          line_bit;
    logic          slot_tick;
    logic          go;
    logic          frame_take;
    logic          frame_done;

    lapd_msg_buf #(.DEPTH(MSG_DEPTH), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (msg_we),
        .waddr (msg_waddr),
        .wdata (msg_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    lapd_bit_src #(.DEPTH(MSG_DEPTH), .AW(AW), .LW(LW)) u_src (
        .clk        (clk),
        .rst        (rst),
        .adv        (adv),
        .go         (go),
        .msg_len    (msg_len),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .bit_out    (line_bit),
        .frame_take (frame_take),
        .frame_done (frame_done)
    );

    lapd_oct_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (line_bit),
        .slot_sel  (slot_sel),
        .slot_gc   (slot_gc),
        .slot_nr   (slot_nr),
        .adv       (adv),
        .slot_tick (slot_tick),
        .oct_data  (oct_data),
        .oct_valid (oct_valid)
    );

    lapd_tx_ctl #(.REPEAT_SLOTS(REPEAT_SLOTS), .TW(TW)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .slot_tick  (slot_tick),
        .frame_take (frame_take),
        .frame_done (frame_done),
        .status_rd  (status_rd),
        .irq_en     (irq_en),
        .go         (go),
        .busy       (busy),
        .int_status (int_status),
        .irq        (irq)
    );

endmodule

// File: tb/lapd_msg_tx_tb.sv
`timescale 1ns/1ps
module lapd_msg_tx_tb;

    localparam int DEPTH = 16;
    localparam int RPT   = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       irq_en = 1'b0;
    logic       status_rd = 1'b0;
    logic       slot_sel = 1'b0;
    logic       slot_gc = 1'b0;
    logic       slot_nr = 1'b0;
    logic       msg_we = 1'b0;
    logic [3:0] msg_waddr = '0;
    logic [7:0] msg_wdata = '0;
    logic [4:0] msg_len = 5'd1;
    logic [7:0] oct_data;
    logic       oct_valid;
    logic       busy;
    logic       int_status;
    logic       irq;

    always #2.5 clk = ~clk;

    lapd_msg_tx #(.MSG_DEPTH(DEPTH), .REPEAT_SLOTS(RPT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .irq_en(irq_en), .status_rd(status_rd),
        .slot_sel(slot_sel), .slot_gc(slot_gc), .slot_nr(slot_nr),
        .msg_we(msg_we), .msg_waddr(msg_waddr), .msg_wdata(msg_wdata), .msg_len(msg_len),
        .oct_data(oct_data), .oct_valid(oct_valid), .busy(busy),
        .int_status(int_status), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    int oct_cnt = 0;
    int sel_cnt = 0;
    int nrx = 0;
    int ones = 0;
    int last_end = -1;
    bit rep_mode = 1'b0;
    bit prev_sel = 1'b0;
    bit dq[$];
    logic [7:0] exp_bytes[$];
    int exp_len[$];
    logic [7:0] msg_img[DEPTH];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_frame(input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            exp_bytes.push_back(msg_img[i]);
            for (int k = 0; k < 8; k++) begin
                if ((c[0] ^ msg_img[i][k]) == 1'b1) c = (c >> 1) ^ 16'h8408;
                else c = c >> 1;
            end
        end
        c = ~c;
        exp_bytes.push_back(c[7:0]);
        exp_bytes.push_back(c[15:8]);
        exp_len.push_back(n + 2);
    endtask

    task automatic frame_end();
        int nb;
        int el;
        logic [7:0] got;
        logic [7:0] e;
        nrx++;
        // R2 whole octets between flags
        chk(dq.size() % 8 == 0, "R2", "frame bit count multiple of 8", dq.size(), 0);
        nb = dq.size() / 8;
        if (exp_len.size() == 0) begin
            // R4 R5 no unexpected frame
            chk(1'b0, "R4", "unexpected frame bytes", nb, 0);
        end else begin
            el = exp_len.pop_front();
            chk(nb == el, "R2", "frame byte count", nb, el);
            for (int i = 0; i < el; i++) begin
                e = exp_bytes.pop_front();
                if (i < nb) begin
                    for (int j = 0; j < 8; j++) got[j] = dq[i*8+j];
                    // R1 R2 R10 content after destuffing, CRC bytes included
                    chk(got == e, "R2", $sformatf("byte %0d", i), got, e);
                end
            end
        end
        if (rep_mode && last_end >= 0)
            // R5 spacing between repeated frames in slots
            chk((oct_cnt - last_end >= RPT - 2) && (oct_cnt - last_end <= RPT + 4),
                "R5", "repeat spacing", oct_cnt - last_end, RPT);
        last_end = oct_cnt;
    endtask

    task automatic decode(input logic [7:0] o);
        for (int k = 0; k < 8; k++) begin
            if (o[k]) begin
                ones++;
                if (ones == 7) begin
                    // R1 R3 never seven ones
                    chk(1'b0, "R1", "seven ones on line", ones, 6);
                    ones = 0;
                    dq.delete();
                end else begin
                    dq.push_back(1'b1);
                end
            end else begin
                if (ones == 5) begin
                    ones = 0;
                end else if (ones == 6) begin
                    ones = 0;
                    if (dq.size() >= 7) begin
                        for (int r = 0; r < 7; r++) void'(dq.pop_back());
                    end else begin
                        dq.delete();
                    end
                    if (dq.size() > 0) frame_end();
                    dq.delete();
                end else begin
                    ones = 0;
                    dq.push_back(1'b0);
                end
            end
        end
    endtask

    // monitor
    always @(negedge clk) begin
        bit sel_now;
        if (!rst) begin
            sel_now = slot_sel ? slot_nr : slot_gc;
            if (oct_valid || prev_sel)
                // R6 one octet, one cycle after each selected strobe
                chk(oct_valid == prev_sel, "R6", "oct_valid after selected strobe", oct_valid, prev_sel);
            prev_sel = sel_now;
            if (sel_now) sel_cnt++;
            if (oct_valid) begin
                oct_cnt++;
                if (oct_cnt == 1) chk(oct_data == 8'h7E, "R3", "first octet after reset", oct_data, 8'h7E);
                decode(oct_data);
            end
        end
    end

    // slot strobe driver
    initial begin
        wait (!rst);
        repeat (20) @(posedge clk);
        forever begin
            for (int p = 0; p < 16; p++) begin
                @(posedge clk);
                #1;
                slot_gc = (p == 0);
                slot_nr = (p == 8);
            end
        end
    end

    task automatic load_msg(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            msg_we = 1'b1; msg_waddr = 4'(i); msg_wdata = msg_img[i];
        end
        @(posedge clk); #1;
        msg_we = 1'b0;
        msg_len = 5'(n);
    endtask

    task automatic wait_slots(input int n);
        int t;
        t = oct_cnt + n;
        while (oct_cnt < t) @(negedge clk);
    endtask

    task automatic wait_frames(input int n);
        while (nrx < n) @(negedge clk);
    endtask

    task automatic read_status();
        @(posedge clk); #1; status_rd = 1'b1;
        @(posedge clk); #1; status_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_slot_counts(input string what);
        @(negedge clk);
        // R6 unselected position strobes produce no octet
        chk((sel_cnt - oct_cnt == 0) || (sel_cnt - oct_cnt == 1), "R6", what, oct_cnt, sel_cnt);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R7", "busy after reset", busy, 0);
        chk(int_status == 1'b0, "R8", "int_status after reset", int_status, 0);
        chk(irq == 1'b0, "R9", "irq after reset", irq, 0);

        // A: GC position, pulsed start, stuffing-heavy content
        msg_img[0] = 8'hFF; msg_img[1] = 8'h7E; msg_img[2] = 8'h3E; msg_img[3] = 8'hF8;
        load_msg(4);
        push_frame(4);
        @(posedge clk); #1 start = 1'b1;
        repeat (3) @(posedge clk);
        #1 start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R7", "busy after start edge", busy, 1);
        wait_frames(1);
        chk(busy == 1'b0, "R7", "busy after frame", busy, 0);
        chk(int_status == 1'b1, "R8", "int_status after frame", int_status, 1);
        chk(irq == 1'b0, "R9", "irq disabled", irq, 0);
        wait_slots(3 * RPT);
        chk(nrx == 1, "R4", "single frame from pulse", nrx, 1);
        check_slot_counts("GC strobes only");
        read_status();
        chk(int_status == 1'b0, "R8", "int_status cleared by read", int_status, 0);

        // B: NR position, one-byte message, interrupt enabled
        @(posedge clk); #1 slot_sel = 1'b1; irq_en = 1'b1;
        msg_img[0] = 8'h00;
        load_msg(1);
        push_frame(1);
        @(posedge clk); #1 start = 1'b1;
        repeat (2) @(posedge clk);
        #1 start = 1'b0;
        wait_frames(2);
        chk(irq == 1'b1, "R9", "irq enabled after frame", irq, 1);
        wait_slots(RPT);
        check_slot_counts("NR strobes only");
        read_status();
        chk(irq == 1'b0, "R9", "irq after read", irq, 0);

        // C: full-length message, start held high, repeats
        @(posedge clk); #1 slot_sel = 1'b0; irq_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) msg_img[i] = 8'(i * 29 + 15);
        load_msg(DEPTH);
        for (int r = 0; r < 5; r++) push_frame(DEPTH);
        rep_mode = 1'b1;
        last_end = -1;
        @(posedge clk); #1 start = 1'b1;
        wait_slots(5);
        chk(busy == 1'b1, "R7", "busy during frame", busy, 1);
        wait_slots(175);
        @(posedge clk); #1 start = 1'b0;
        wait_slots(3 * RPT);
        rep_mode = 1'b0;
        chk(nrx == 7, "R5", "repeat frame count", nrx, 7);
        chk(exp_len.size() == 0, "R5", "expected frames left", exp_len.size(), 0);
        chk(int_status == 1'b1, "R8", "sticky over several completions", int_status, 1);
        check_slot_counts("GC strobes after switch back");
        read_status();
        chk(int_status == 1'b0, "R8", "int_status cleared after repeats", int_status, 0);

        summary();
        $finish;
    end

endmodule